// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs each access a small controller makes to memory outside the chip. The external space is 4 MB wide. The top address bit splits it into a lower half and an upper half, so that a slow device and a fast device can be fitted side by side. For every access the block drives an address strobe phase and then a data strobe phase, and then raises a one-cycle completion pulse. Each half has its own data strobe pin, which lets the pin select its memory device directly. Each half also has its own programmable count of extra cycles that lengthen its data strobe phase. The upper half alone can also lengthen its address strobe phase.

Two small configuration registers hold the timing. The wait control register holds both data-phase stretch fields and a watchdog enable bit. The block only stores that bit and drives it out. A second register holds the 2-bit upper-half address-phase stretch. Reset loads the slowest timing. Software can shorten it once the attached devices are known to be fast enough. Configuration writes are refused while the interrupt-in-service input is high. All stretch cycles are counted on the clock that the block runs on.

Top module: `ext_wait_gen`

## Requirements
- R1: After reset the wait control register reads 7Fh, the address-phase stretch reads 3, `wdog_en` is 1, and `busy`, `addr_strobe`, `ds_lower`, `ds_upper` and `done` are all 0.
- R2: Address bit 21 picks the block: 1 selects the upper half and drives `ds_upper`, 0 selects the lower half and drives `ds_lower`. The strobe of the other block stays 0 for the whole access.
- R3: The address strobe phase lasts 1 cycle plus the address-phase stretch for an upper access. It always lasts exactly 1 cycle for a lower access.
- R4: The data strobe phase lasts 1 cycle plus the selected block's data stretch. The upper stretch is wait control bits 5:3 and the lower stretch is bits 2:0, so 0 to 7 extra cycles are possible.
- R5: Right after the data phase, `done` is high for exactly one cycle and the block then returns to idle. `busy` is high from the cycle after a request is taken until the `done` cycle ends. While `busy` is high, `bus_addr` and `acc_write` hold the address and write flag of that request.
- R6: Wait control bit 7 always reads 0, whatever value is written. Bit 6 is stored and drives `wdog_en`.
- R7: While `irq_active` is 1, a write to either register (`cfg_sel` 0 = wait control, `cfg_sel` 1 = address-phase stretch in `cfg_wdata[1:0]`) leaves it unchanged.
- R8: The stretch values are captured when a request is taken. A register write made during an access changes only later accesses.
- R9: A request is taken only while idle. A request held during an access is neither taken nor queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all stretch cycles count on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 wait control, 1 address-phase stretch |
| cfg_wdata | input | 8 | Register write data |
| irq_active | input | 1 | Interrupt in service; blocks register writes |
| wctl_q | output | 8 | Wait control register value |
| as_stretch_q | output | 2 | Upper address-phase stretch value |
| wdog_en | output | 1 | Stored watchdog enable bit |
| req_valid | input | 1 | Access request |
| req_addr | input | 22 | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| busy | output | 1 | Access in progress |
| bus_addr | output | 22 | Address held for the current access |
| acc_write | output | 1 | Write flag held for the current access |
| addr_strobe | output | 1 | Address strobe |
| ds_lower | output | 1 | Data strobe for the lower half |
| ds_upper | output | 1 | Data strobe for the upper half |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the length of each phase, cycle by cycle, at the two edges of block selection: address 1FFFFFh and address 200000h. It does this at the reset timing, at mixed stretch values and at zero stretch. A design that swapped the stretch fields or the strobe pins, or that stretched the lower address phase, shows up as a wrong count or a strobe on the wrong pin. Writes are issued during an access and while the interrupt input is high. A design that read the registers live instead of capturing them would change the running access, and one without the lock would pick up the blocked value. A request held through a whole access checks that the sequencer neither restarts nor queues a second access.

// File: rtl/ewg_pkg.sv
package ewg_pkg;
    localparam int ADDR_W  = 22;
    localparam int REG_W   = 8;
    localparam int DS_W    = 3;
    localparam int AS_W    = 2;
    localparam int CNT_W   = (DS_W > AS_W) ? DS_W : AS_W;
    localparam int BLK_BIT = ADDR_W - 1;

    localparam logic [REG_W-1:0] WCTL_RST = 8'h7F;
    localparam logic [AS_W-1:0]  AS_RST   = '1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AS   = 2'd1,
        ST_DS   = 2'd2,
        ST_DONE = 2'd3
    } ewg_state_e;

    typedef struct packed {
        logic [REG_W-1:0] wctl;
        logic [AS_W-1:0]  as_str;
    } ewg_regs_t;

    typedef struct packed {
        ewg_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [DS_W-1:0]   ds_len;
        logic              upper;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } ewg_seq_t;
endpackage

// File: rtl/ewg_cfg_regs.sv
module ewg_cfg_regs
    import ewg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_active,
    output logic [REG_W-1:0] wctl,
    output logic [AS_W-1:0]  as_str,
    output logic [DS_W-1:0]  upper_ds,
    output logic [DS_W-1:0]  lower_ds,
    output logic             wdog
);
    ewg_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && !irq_active) begin
            if (wr_sel) begin
                r_d.as_str = wr_data[AS_W-1:0];
            end else begin
                r_d.wctl = {1'b0, wr_data[REG_W-2:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.wctl   <= WCTL_RST;
            r_q.as_str <= AS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign wctl     = r_q.wctl;
    assign as_str   = r_q.as_str;
    assign wdog     = r_q.wctl[6];
    assign upper_ds = r_q.wctl[2*DS_W-1:DS_W];
    assign lower_ds = r_q.wctl[DS_W-1:0];
endmodule

// File: rtl/ewg_seq.sv
module ewg_seq
    import ewg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [AS_W-1:0]   as_str,
    input  logic [DS_W-1:0]   upper_ds,
    input  logic [DS_W-1:0]   lower_ds,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              acc_write,
    output logic              addr_strobe,
    output logic              ds_lower,
    output logic              ds_upper,
    output logic              done
);
    ewg_seq_t s_d, s_q;
    logic     sel_upper;

    assign sel_upper = req_addr[BLK_BIT];

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.state  = ST_AS;
                    s_d.upper  = sel_upper;
                    s_d.wr     = req_write;
                    s_d.addr   = req_addr;
                    s_d.ds_len = sel_upper ? upper_ds : lower_ds;
                    s_d.cnt    = sel_upper ? CNT_W'(as_str) : '0;
                end
            end
            ST_AS: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_DS;
                    s_d.cnt   = CNT_W'(s_q.ds_len);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_DS: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_DONE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, cnt: '0, ds_len: '0,
                     upper: 1'b0, wr: 1'b0, addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.state != ST_IDLE);
    assign bus_addr    = s_q.addr;
    assign acc_write   = s_q.wr;
    assign addr_strobe = (s_q.state == ST_AS);
    assign ds_lower    = (s_q.state == ST_DS) && !s_q.upper;
    assign ds_upper    = (s_q.state == ST_DS) &&  s_q.upper;
    assign done        = (s_q.state == ST_DONE);
endmodule

// File: rtl/ext_wait_gen.sv
module ext_wait_gen
    import ewg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              irq_active,
    output logic [REG_W-1:0]  wctl_q,
    output logic [AS_W-1:0]   as_stretch_q,
    output logic              wdog_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              acc_write,
    output logic              addr_strobe,
    output logic              ds_lower,
    output logic              ds_upper,
    output logic              done
);
    logic [DS_W-1:0] upper_ds;
    logic [DS_W-1:0] lower_ds;

    ewg_cfg_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata),
        .irq_active (irq_active),
        .wctl       (wctl_q),
        .as_str     (as_stretch_q),
        .upper_ds   (upper_ds),
        .lower_ds   (lower_ds),
        .wdog       (wdog_en)
    );

    ewg_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .as_str      (as_stretch_q),
        .upper_ds    (upper_ds),
        .lower_ds    (lower_ds),
        .busy        (busy),
        .bus_addr    (bus_addr),
        .acc_write   (acc_write),
        .addr_strobe (addr_strobe),
        .ds_lower    (ds_lower),
        .ds_upper    (ds_upper),
        .done        (done)
    );
endmodule

// File: rtl/ewg_checker.sv
module ewg_checker
    import ewg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              irq_active,
    input logic [REG_W-1:0]  wctl_q,
    input logic [AS_W-1:0]   as_stretch_q,
    input logic              req_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              busy,
    input logic              addr_strobe,
    input logic              ds_lower,
    input logic              ds_upper,
    input logic              done
);
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ds_lower && ds_upper));

    p_strobe_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_lower || ds_upper) |-> (ds_upper == bus_addr[BLK_BIT]));

    p_as_to_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_strobe) |-> (ds_lower || ds_upper));

    p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_strobe, ds_lower || ds_upper, done}));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_busy_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe || ds_lower || ds_upper || done) |-> busy);

    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wctl_q[REG_W-1]);

    p_wr_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && irq_active) |=> ($stable(wctl_q) && $stable(as_stretch_q)));

    p_accept_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_start_as_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> addr_strobe);
endmodule

bind ext_wait_gen ewg_checker i_ewg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .irq_active   (irq_active),
    .wctl_q       (wctl_q),
    .as_stretch_q (as_stretch_q),
    .req_valid    (req_valid),
    .bus_addr     (bus_addr),
    .busy         (busy),
    .addr_strobe  (addr_strobe),
    .ds_lower     (ds_lower),
    .ds_upper     (ds_upper),
    .done         (done)
);

// File: tb/test_ext_wait_gen.sv
module test_ext_wait_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        irq_active = 1'b0;
    logic [7:0]  wctl_q;
    logic [1:0]  as_stretch_q;
    logic        wdog_en;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        busy;
    logic [21:0] bus_addr;
    logic        acc_write;
    logic        addr_strobe;
    logic        ds_lower;
    logic        ds_upper;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ext_wait_gen i_ext_wait_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_active(irq_active), .wctl_q(wctl_q),
        .as_stretch_q(as_stretch_q), .wdog_en(wdog_en), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .busy(busy),
        .bus_addr(bus_addr), .acc_write(acc_write), .addr_strobe(addr_strobe),
        .ds_lower(ds_lower), .ds_upper(ds_upper), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input bit sel, input logic [7:0] data);
        @(negedge clk);
        cfg_sel   = sel;
        cfg_wdata = data;
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Runs one access and measures each phase at negative edges.
    task automatic do_access(input logic [21:0] a, input bit wr,
                             input int exp_as, input int exp_ds,
                             input bit hold, input bit mid_wr,
                             input logic [7:0] mid_data, input string req);
        int  n_as = 0;
        int  n_ds = 0;
        bit  up   = a[21];
        bit  wrong_pin = 1'b0;
        bit  hold_ok = 1'b1;
        @(negedge clk);
        req_addr  = a;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        if (mid_wr) begin
            cfg_sel = 1'b0; cfg_wdata = mid_data; cfg_wr_en = 1'b1;
        end
        check(bus_addr == a && acc_write == wr && busy, "R5", "captured addr/flag",
              int'(bus_addr), int'(a));
        while (addr_strobe && n_as < 20) begin
            if (ds_lower || ds_upper) wrong_pin = 1'b1;
            if (bus_addr != a || acc_write != wr || !busy) hold_ok = 1'b0;
            n_as++;
            @(negedge clk);
            cfg_wr_en = 1'b0;
        end
        while ((ds_lower || ds_upper) && n_ds < 20) begin
            if (up ? ds_lower : ds_upper) wrong_pin = 1'b1;
            if (bus_addr != a || acc_write != wr || !busy) hold_ok = 1'b0;
            n_ds++;
            @(negedge clk);
            cfg_wr_en = 1'b0;
        end
        check(n_as == exp_as, req, "address phase length", n_as, exp_as);
        check(n_ds == exp_ds, req, "data phase length", n_ds, exp_ds);
        check(!wrong_pin, "R2", "data strobe pin for block", int'(up), int'(up));
        check(hold_ok, "R5", "address and flag held while busy", 0, 1);
        check(done && busy, "R5", "done pulse after data phase",
              int'({done, busy}), 3);
        req_valid = 1'b0;
        @(negedge clk);
        check(!done && !busy && !addr_strobe, "R5", "idle after done",
              int'({done, busy, addr_strobe}), 0);
    endtask

    task automatic t_reset;
        check(wctl_q == 8'h7F, "R1", "wait control reset", wctl_q, 8'h7F);
        check(as_stretch_q == 2'd3, "R1", "address stretch reset", as_stretch_q, 3);
        check(wdog_en == 1'b1, "R1", "watchdog enable reset", wdog_en, 1);
        check({busy, addr_strobe, ds_lower, ds_upper, done} == '0, "R1",
              "idle outputs", int'({busy, addr_strobe, ds_lower, ds_upper, done}), 0);
    endtask

    task automatic t_default_timing;
        do_access(22'h200000, 1'b0, 4, 8, 1'b0, 1'b0, 8'h00, "R3 R4 upper reset");
        do_access(22'h1FFFFF, 1'b1, 1, 8, 1'b0, 1'b0, 8'h00, "R3 R4 lower reset");
    endtask

    task automatic t_reserved_bit;
        reg_write(1'b0, 8'hFF);
        check(wctl_q == 8'h7F, "R6", "bit 7 reads 0", wctl_q, 8'h7F);
        reg_write(1'b0, 8'h2A);
        check(wctl_q == 8'h2A, "R6", "wait control write", wctl_q, 8'h2A);
        check(wdog_en == 1'b0, "R6", "watchdog follows bit 6", wdog_en, 0);
    endtask

    task automatic t_mixed_timing;
        reg_write(1'b1, 8'h01);
        check(as_stretch_q == 2'd1, "R3", "address stretch write", as_stretch_q, 1);
        do_access(22'h3ABCDE, 1'b1, 2, 6, 1'b0, 1'b0, 8'h00, "R3 R4 upper mixed");
        do_access(22'h012345, 1'b0, 1, 3, 1'b0, 1'b0, 8'h00, "R3 R4 lower mixed");
    endtask

    task automatic t_zero_timing;
        reg_write(1'b0, 8'h40);
        reg_write(1'b1, 8'h00);
        do_access(22'h200000, 1'b0, 1, 1, 1'b0, 1'b0, 8'h00, "R3 R4 upper zero");
        do_access(22'h1FFFFF, 1'b0, 1, 1, 1'b0, 1'b0, 8'h00, "R3 R4 lower zero");
    endtask

    task automatic t_irq_lock;
        irq_active = 1'b1;
        reg_write(1'b0, 8'h3F);
        reg_write(1'b1, 8'h03);
        check(wctl_q == 8'h40, "R7", "wait control locked", wctl_q, 8'h40);
        check(as_stretch_q == 2'd0, "R7", "address stretch locked", as_stretch_q, 0);
        do_access(22'h300000, 1'b0, 1, 1, 1'b0, 1'b0, 8'h00, "R7 timing unchanged");
        irq_active = 1'b0;
    endtask

    task automatic t_sample_at_accept;
        reg_write(1'b0, 8'h45);
        do_access(22'h100000, 1'b0, 1, 6, 1'b0, 1'b1, 8'h40, "R8 captured stretch");
        check(wctl_q == 8'h40, "R8", "mid-access write landed", wctl_q, 8'h40);
        do_access(22'h100000, 1'b0, 1, 1, 1'b0, 1'b0, 8'h00, "R8 next access");
    endtask

    task automatic t_held_request;
        reg_write(1'b0, 8'h50);
        do_access(22'h250000, 1'b1, 1, 3, 1'b1, 1'b0, 8'h00, "R9 held request");
        @(negedge clk);
        check(!busy && !addr_strobe, "R9", "no queued access", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_timing();
        t_reserved_bit();
        t_mixed_timing();
        t_zero_timing();
        t_irq_lock();
        t_sample_at_accept();
        t_held_request();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule